// File: doc/BRIEF.md
# Host-Slave Handshake Mailbox

This block is a small register mailbox shared by a host bus and a slave processor bus. Both buses use the same clock. Each side has a plain synchronous register port with an address, a write strobe, a read strobe, write data and registered read data. Through these ports both sides reach the same three locations: an 8-bit data register, an 8-bit control/status register and a one-bit busy flag.

A transfer begins when the host writes a control code and then sets the busy flag. Setting the flag raises an interrupt request toward the slave. The slave reads the flag and finds it set. It then handles the control code and writes a status code back into the same control/status register. Finally it clears the flag by writing 0. Set and clear rights are asymmetric. Only the host can set the flag. Only the slave can clear it, and only after it has observed the flag as 1.

Top module: `mbox_hs`

## Requirements
- R1: After reset the busy flag, the interrupt request, both registers and both read-data outputs are all 0.
- R2: A host write of 1 to bit 0 of address 2 sets the busy flag. A host write of 0 there leaves the flag unchanged.
- R3: The slave cannot set the flag. A slave write of 1 to bit 0 of address 2 changes nothing and does not use up a prior qualifying read.
- R4: A slave write of 0 to bit 0 of address 2 clears the flag if an earlier slave read of address 2 returned the flag as 1.
- R5: One qualifying read enables exactly one slave clear write. A clear write made without a qualifying read since the last clear write leaves the flag at 1.
- R6: The slave interrupt request goes high in the cycle after the flag changes from 0 to 1. It stays high until the slave pulses the acknowledge input.
- R7: The data register is at address 0 and both sides can read and write it. A read returns the contents held in the cycle of the read, one clock later. Address 3 reads as 0, and address 2 returns the flag in bit 0 with all other bits 0.
- R8: The control/status register is at address 1. The host writes a code there, and the slave reads that code and writes a status value back into the same register, which the host can then read.
- R9: If both sides write the same register in one cycle, the register takes the host value.
- R10: If a host set and a slave clear of the flag fall in the same cycle, the flag ends at 1.
- R11: Each read-data output keeps its value when no read is made on that side, even while the other side writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid one cycle after the read |
| slave_addr | input | 2 | Slave register select |
| slave_wr | input | 1 | Slave write strobe |
| slave_rd | input | 1 | Slave read strobe |
| slave_wdata | input | 8 | Slave write data |
| slave_rdata | output | 8 | Slave read data, valid one cycle after the read |
| slave_irq | output | 1 | Interrupt request raised when the flag is set |
| slave_irq_ack | input | 1 | Slave pulse that drops the interrupt request |

## Verification
The case hardest to reach is a collision on the flag. In one cycle the host sets it while the slave issues a clear that is backed by a valid qualifying read. The result must be a flag left at 1 and a read permission that is used up. To build this, the stimulus first has the slave read the flag while it is 1, which arms the clear. It then drives both writes on the same clock edge. Next it shows that a second clear, now without a read, leaves the flag set. Only after a fresh read does a clear succeed.

// File: rtl/mbox_hs_pkg.sv
package mbox_hs_pkg;
  // register map; the flag location and bit are decoded by both sides
  localparam int REG_DATA = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_FLAG = 2;
  localparam int NUM_SHARED = 2;   // data and control/status cells
endpackage

// File: rtl/mbox_hs_cell.sv
module mbox_hs_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hi_we,
  input  logic [W-1:0] hi_d,
  input  logic         lo_we,
  input  logic [W-1:0] lo_d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         q_en;

  // host side (hi) has priority over slave side (lo)
  always_comb begin
    q_en = hi_we | lo_we;
    q_d  = hi_we ? hi_d : lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/mbox_hs_flag.sv
module mbox_hs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic host_set_wr,
  input  logic host_bit,
  input  logic slave_flag_wr,
  input  logic slave_bit,
  input  logic slave_flag_rd,
  input  logic irq_ack,
  output logic busy,
  output logic armed,
  output logic irq
);
  logic busy_r, busy_d, busy_en;
  logic arm_r, arm_d, arm_en;
  logic irq_r, irq_d, irq_en;
  logic set_req, clr_req, clr_ok, rd_hit;

  always_comb begin
    set_req = host_set_wr & host_bit;
    clr_req = slave_flag_wr & ~slave_bit;
    clr_ok  = clr_req & arm_r;
    rd_hit  = slave_flag_rd & busy_r;

    // host set wins over a simultaneous qualified clear
    busy_en = set_req | clr_ok;
    busy_d  = set_req;

    // any clear write consumes the permission; a read of 1 grants it
    arm_en  = clr_req | rd_hit;
    arm_d   = ~clr_req;

    irq_en  = (set_req & ~busy_r) | irq_ack;
    irq_d   = set_req & ~busy_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_r <= 1'b0;
    else if (busy_en) busy_r <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_r <= 1'b0;
    else if (arm_en) arm_r <= arm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_r <= 1'b0;
    else if (irq_en) irq_r <= irq_d;
  end

  assign busy  = busy_r;
  assign armed = arm_r;
  assign irq   = irq_r;
endmodule

// File: rtl/mbox_hs_rdport.sv
module mbox_hs_rdport
  import mbox_hs_pkg::*;
#(
  parameter int W        = 8,
  parameter int AW       = 2,
  parameter int FLAG_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  data_q,
  input  logic [W-1:0]  ctrl_q,
  input  logic          busy,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] sel_val;
  logic [W-1:0] rd_r;

  always_comb begin
    sel_val = '0;
    if (addr == AW'(REG_DATA))      sel_val = data_q;
    else if (addr == AW'(REG_CTRL)) sel_val = ctrl_q;
    else if (addr == AW'(REG_FLAG)) sel_val[FLAG_BIT] = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_r <= '0;
    else if (rd) rd_r <= sel_val;
  end

  assign rdata = rd_r;
endmodule

// File: rtl/mbox_hs.sv
module mbox_hs
  import mbox_hs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int FLAG_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              slave_wr,
  input  logic              slave_rd,
  input  logic [DATA_W-1:0] slave_wdata,
  output logic [DATA_W-1:0] slave_rdata,
  output logic              slave_irq,
  input  logic              slave_irq_ack
);
  logic [DATA_W-1:0] cell_q [NUM_SHARED];
  logic busy_w, armed_w;
  logic host_flag_sel, slave_flag_sel;

  assign host_flag_sel  = host_addr  == ADDR_W'(REG_FLAG);
  assign slave_flag_sel = slave_addr == ADDR_W'(REG_FLAG);

  for (genvar g = 0; g < NUM_SHARED; g++) begin : g_cell
    logic h_we, s_we;
    assign h_we = host_wr  & (host_addr  == ADDR_W'(g));
    assign s_we = slave_wr & (slave_addr == ADDR_W'(g));
    mbox_hs_cell #(.W(DATA_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_we (h_we),
      .hi_d  (host_wdata),
      .lo_we (s_we),
      .lo_d  (slave_wdata),
      .q     (cell_q[g])
    );
  end

  mbox_hs_flag u_flag (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_set_wr   (host_wr & host_flag_sel),
    .host_bit      (host_wdata[FLAG_BIT]),
    .slave_flag_wr (slave_wr & slave_flag_sel),
    .slave_bit     (slave_wdata[FLAG_BIT]),
    .slave_flag_rd (slave_rd & slave_flag_sel),
    .irq_ack       (slave_irq_ack),
    .busy          (busy_w),
    .armed         (armed_w),
    .irq           (slave_irq)
  );

  mbox_hs_rdport #(.W(DATA_W), .AW(ADDR_W), .FLAG_BIT(FLAG_BIT)) u_hrd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (host_rd),
    .addr   (host_addr),
    .data_q (cell_q[REG_DATA]),
    .ctrl_q (cell_q[REG_CTRL]),
    .busy   (busy_w),
    .rdata  (host_rdata)
  );

  mbox_hs_rdport #(.W(DATA_W), .AW(ADDR_W), .FLAG_BIT(FLAG_BIT)) u_srd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (slave_rd),
    .addr   (slave_addr),
    .data_q (cell_q[REG_DATA]),
    .ctrl_q (cell_q[REG_CTRL]),
    .busy   (busy_w),
    .rdata  (slave_rdata)
  );
endmodule

// File: rtl/mbox_hs_chk.sv
module mbox_hs_chk
  import mbox_hs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int FLAG_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic              host_wbit,
  input logic [DATA_W-1:0] host_rdata,
  input logic [ADDR_W-1:0] slave_addr,
  input logic              slave_wr,
  input logic              slave_rd,
  input logic              slave_wbit,
  input logic [DATA_W-1:0] slave_rdata,
  input logic              slave_irq,
  input logic              slave_irq_ack,
  input logic              busy,
  input logic              armed
);
  logic h_set, s_clr, h_frd, s_frd;
  assign h_set = host_wr  & (host_addr  == ADDR_W'(REG_FLAG)) & host_wbit;
  assign s_clr = slave_wr & (slave_addr == ADDR_W'(REG_FLAG)) & ~slave_wbit;
  assign h_frd = host_rd  & (host_addr  == ADDR_W'(REG_FLAG));
  assign s_frd = slave_rd & (slave_addr == ADDR_W'(REG_FLAG));

  AST_BUSY_RISE_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(h_set)); // R2
  AST_BUSY_FALL_FROM_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(s_clr)); // R4
  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(armed)); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    h_set |=> busy); // R10
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> slave_irq); // R6
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_irq && !slave_irq_ack) |=> slave_irq); // R6
  AST_HOST_FLAG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    h_frd |=> host_rdata[FLAG_BIT] == $past(busy)); // R7
  AST_SLAVE_FLAG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    s_frd |=> slave_rdata[FLAG_BIT] == $past(busy)); // R7
  AST_HOST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata)); // R11
  AST_SLAVE_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_rd |=> $stable(slave_rdata)); // R11
endmodule

bind mbox_hs mbox_hs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_addr     (host_addr),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .host_wbit     (host_wdata[FLAG_BIT]),
  .host_rdata    (host_rdata),
  .slave_addr    (slave_addr),
  .slave_wr      (slave_wr),
  .slave_rd      (slave_rd),
  .slave_wbit    (slave_wdata[FLAG_BIT]),
  .slave_rdata   (slave_rdata),
  .slave_irq     (slave_irq),
  .slave_irq_ack (slave_irq_ack),
  .busy          (busy_w),
  .armed         (armed_w)
);

// File: tb/sim_mbox_hs.sv
module sim_mbox_hs;
  localparam int AD = 0;  // data
  localparam int AC = 1;  // control/status
  localparam int AF = 2;  // flag
  localparam int KH = 0;  // host rdata
  localparam int KS = 1;  // slave rdata
  localparam int KI = 2;  // slave_irq

  logic       clk;
  logic       rst_n;
  logic [1:0] host_addr, slave_addr;
  logic       host_wr, host_rd, slave_wr, slave_rd, slave_irq_ack;
  logic [7:0] host_wdata, slave_wdata;
  logic [7:0] host_rdata, slave_rdata;
  logic       slave_irq;

  typedef struct {int kind; int exp; int req;} item_t;
  item_t sb[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  mbox_hs u0 (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .slave_addr(slave_addr), .slave_wr(slave_wr), .slave_rd(slave_rd),
    .slave_wdata(slave_wdata), .slave_rdata(slave_rdata),
    .slave_irq(slave_irq), .slave_irq_ack(slave_irq_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input int req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input int kind, input int exp, input int req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: every queued item is due right after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        case (it.kind)
          KH:      check(it.req, int'(host_rdata),  it.exp, "host_rdata");
          KS:      check(it.req, int'(slave_rdata), it.exp, "slave_rdata");
          default: check(it.req, int'(slave_irq),   it.exp, "slave_irq");
        endcase
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; host_rd = 0; slave_wr = 0; slave_rd = 0; slave_irq_ack = 0;
  endtask

  task automatic hwr(input int a, input int d);
    host_wr = 1; host_addr = 2'(a); host_wdata = 8'(d); tick();
  endtask
  task automatic swr(input int a, input int d);
    slave_wr = 1; slave_addr = 2'(a); slave_wdata = 8'(d); tick();
  endtask
  task automatic hrd(input int a, input int exp, input int req);
    host_rd = 1; host_addr = 2'(a); expect_item(KH, exp, req); tick();
  endtask
  task automatic srd(input int a, input int exp, input int req);
    slave_rd = 1; slave_addr = 2'(a); expect_item(KS, exp, req); tick();
  endtask
  task automatic ack(input int req);
    slave_irq_ack = 1; expect_item(KI, 0, req); tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    host_addr = 0; slave_addr = 0; host_wdata = 0; slave_wdata = 0;
    host_wr = 0; host_rd = 0; slave_wr = 0; slave_rd = 0; slave_irq_ack = 0;
    repeat (3) @(negedge clk);
    check(1, int'(host_rdata), 0, "host_rdata in reset");   // R1
    check(1, int'(slave_rdata), 0, "slave_rdata in reset"); // R1
    check(1, int'(slave_irq), 0, "slave_irq in reset");     // R1
    rst_n = 1;
    @(negedge clk);
    // R1: registers and flag start at zero
    hrd(AD, 0, 1);
    hrd(AC, 0, 1);
    srd(AF, 0, 1);
    // R2: host write of 0 does nothing
    expect_item(KI, 0, 2);
    hwr(AF, 0);
    srd(AF, 0, 2);
    // R3: slave cannot set
    swr(AF, 1);
    hrd(AF, 0, 3);
    // R2 / R6: host set raises flag and interrupt
    expect_item(KI, 1, 6);
    hwr(AF, 1);
    hrd(AF, 1, 2);
    for (int i = 0; i < 3; i++) begin
      expect_item(KI, 1, 6); tick();  // R6 held
    end
    ack(6);
    // R5: clear without qualifying read leaves it set
    swr(AF, 0);
    hrd(AF, 1, 5);
    // R4 with R3: read arms, write of 1 ignored, write of 0 clears
    srd(AF, 1, 4);
    swr(AF, 1);
    hrd(AF, 1, 3);
    swr(AF, 0);
    hrd(AF, 0, 4);
    // R5: permission was consumed by that clear
    expect_item(KI, 1, 6);
    hwr(AF, 1);
    ack(6);
    swr(AF, 0);
    srd(AF, 1, 5);  // also arms
    // R10: armed clear collides with host set
    host_wr = 1; host_addr = 2'(AF); host_wdata = 8'h01;
    slave_wr = 1; slave_addr = 2'(AF); slave_wdata = 8'h00;
    expect_item(KI, 0, 10);
    tick();
    hrd(AF, 1, 10);
    swr(AF, 0);     // permission consumed by the collision
    hrd(AF, 1, 5);
    srd(AF, 1, 4);
    swr(AF, 0);
    hrd(AF, 0, 4);
    // R10: collision while flag is 0 and unarmed
    host_wr = 1; host_addr = 2'(AF); host_wdata = 8'h01;
    slave_wr = 1; slave_addr = 2'(AF); slave_wdata = 8'h00;
    expect_item(KI, 1, 10);
    tick();
    hrd(AF, 1, 10);
    ack(6);
    // R7: data register both ways, unmapped address
    hwr(AD, 8'hA5);
    srd(AD, 8'hA5, 7);
    swr(AD, 8'h3C);
    hrd(AD, 8'h3C, 7);
    hrd(3, 0, 7);
    // R8: control code out, status back
    hwr(AC, 8'h61);
    srd(AC, 8'h61, 8);
    swr(AC, 8'h80);
    hrd(AC, 8'h80, 8);
    // R9: simultaneous writes, host wins
    host_wr = 1; host_addr = 2'(AD); host_wdata = 8'h11;
    slave_wr = 1; slave_addr = 2'(AD); slave_wdata = 8'h22;
    tick();
    srd(AD, 8'h11, 9);
    host_wr = 1; host_addr = 2'(AC); host_wdata = 8'h4E;
    slave_wr = 1; slave_addr = 2'(AC); slave_wdata = 8'h99;
    tick();
    hrd(AC, 8'h4E, 9);
    // R11: read data held without a read
    hrd(AD, 8'h11, 7);
    slave_wr = 1; slave_addr = 2'(AD); slave_wdata = 8'h77;
    expect_item(KH, 8'h11, 11);
    tick();
    expect_item(KH, 8'h11, 11);
    tick();
    // R7: read in the same cycle as a write returns the old contents
    host_rd = 1; host_wr = 1; host_addr = 2'(AD); host_wdata = 8'h5A;
    expect_item(KH, 8'h77, 7);
    tick();
    hrd(AD, 8'h5A, 7);
    tick();
    tick();
    check(0, sb.size(), 0, "scoreboard drained (all requirements)");
    done = 1;
    summary();
    $finish;
  end
endmodule